// File: doc/BRIEF.md
# Sixteen-Register Multi-Cycle Teaching Processor

This block is a small multi-cycle processor with a 16-bit word, sixteen general registers, an 8-bit program counter and one 256-word memory that holds both code and data. Each instruction passes through fetch, operand read and execute steps, plus a wait step for stream transfers. The instruction set has sixteen opcodes in two formats. It covers arithmetic, logic, shifts, direct and indirect memory access, conditional branches, a register jump and a jump that saves a return address.

The top memory address is not storage. A load from it takes the next word from an input stream, and a store to it sends a word out on an output stream. Both streams use a valid/ready handshake, and the processor waits until the transfer completes. While reset is held, a testbench fills memory through a preload write port. After reset is released the processor runs until it meets a halt instruction. It then raises a halted flag and stays stopped until the next reset.

Top module: `mini16_cpu`

## Requirements
- R1: While reset is held all registers clear to zero and `halted`, `inReady` and `outValid` are low. After reset is released the first instruction fetched is the one at address 0x10.
- R2: Instruction fields are fixed: opcode in bits 15:12, destination d in bits 11:8, source s in bits 7:4, source t in bits 3:0, and the 8-bit address or immediate in bits 7:0.
- R3: Opcode 1 writes Rs+Rt, 2 writes Rs-Rt, 3 writes Rs AND Rt and 4 writes Rs XOR Rt into Rd. Results wrap modulo 2^16.
- R4: Opcode 5 shifts Rs left by Rt and opcode 6 shifts Rs right logically by Rt. Any shift amount of 16 or more gives zero.
- R5: Register 0 always reads as zero. Any write to it is discarded.
- R6: Opcode 7 loads the zero-extended immediate into Rd. Opcode 8 loads memory at the address field and opcode 9 stores Rd there. Opcodes A and B load and store at the address given by the low 8 bits of Rt.
- R7: A load (direct or indirect) from address 0xFF raises `inReady` and holds it until `inValid` is seen. The accepted `inData` word goes to Rd.
- R8: A store to address 0xFF raises `outValid` with Rd on `outData`. Both stay steady until `outReady` is seen, and memory is left unchanged.
- R9: Opcode C branches to the address field when Rd is zero. Opcode D branches when Rd is nonzero with bit 15 clear. Otherwise execution falls through.
- R10: Opcode E jumps to the low 8 bits of Rd. Opcode F writes the address of the next instruction into Rd and then jumps to the address field.
- R11: Opcode 0 raises `halted`. No further fetch or stream activity happens until reset.
- R12: The preload port writes memory only while reset is held. Preload writes made while the processor runs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loadEn | input | 1 | Preload write strobe, honoured only in reset |
| loadAddr | input | 8 | Preload word address |
| loadData | input | 16 | Preload word |
| inData | input | 16 | Input stream word |
| inValid | input | 1 | Input stream word present |
| inReady | output | 1 | Processor waits for an input word |
| outData | output | 16 | Output stream word |
| outValid | output | 1 | Output stream word present |
| outReady | input | 1 | Output stream word taken |
| halted | output | 1 | Processor stopped by a halt instruction |

## Verification
Each program is also run through an instruction-level model inside the bench, and the model's output stream is compared word for word with the design's. An echo program that reads until zero uses the input and output address, indirect stores and loop branches. It is run once with free-flowing streams and once with valid and ready withdrawn on many cycles, which separates correct stalling from lost or duplicated words. A program made of arithmetic, logic and shift instructions covers operand order, wraparound, shift amounts past the word width and discarded writes to register zero. A control-flow program uses a negative, a positive and a zero register value to separate the two branch conditions, and it prints the saved return address. Further runs check that preload writes are ignored after reset and that a halt stays in effect.

// File: rtl/mini16_pkg.sv
package mini16_pkg;

  localparam int INSN_W = 16;
  localparam int REG_AW = 4;

  localparam logic [3:0] OP_HALT = 4'h0;
  localparam logic [3:0] OP_ADD  = 4'h1;
  localparam logic [3:0] OP_SUB  = 4'h2;
  localparam logic [3:0] OP_AND  = 4'h3;
  localparam logic [3:0] OP_XOR  = 4'h4;
  localparam logic [3:0] OP_SHL  = 4'h5;
  localparam logic [3:0] OP_SHR  = 4'h6;
  localparam logic [3:0] OP_LDA  = 4'h7;
  localparam logic [3:0] OP_LD   = 4'h8;
  localparam logic [3:0] OP_ST   = 4'h9;
  localparam logic [3:0] OP_LDI  = 4'hA;
  localparam logic [3:0] OP_STI  = 4'hB;
  localparam logic [3:0] OP_BZ   = 4'hC;
  localparam logic [3:0] OP_BP   = 4'hD;
  localparam logic [3:0] OP_JR   = 4'hE;
  localparam logic [3:0] OP_JAL  = 4'hF;

  typedef enum logic [2:0] {
    WB_ALU,
    WB_IMM,
    WB_MEM,
    WB_IN,
    WB_PC
  } wbSel_t;

  typedef struct packed {
    logic   irLoad;
    logic   opLatch;
    logic   regWr;
    wbSel_t wbSel;
    logic   memWr;
    logic   pcJump;
    logic   pcFromReg;
  } ctrlStrobe_t;

endpackage

// File: rtl/mini16_dpath.sv
module mini16_dpath
  import mini16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       st,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic [3:0]        opcode,
  output logic              ioAddr,
  output logic              dIsZero,
  output logic              dIsPos
);

  localparam int DEPTH   = 1 << ADDR_W;
  localparam int NREG    = 1 << REG_AW;
  localparam int SH_W    = $clog2(DATA_W);
  localparam int EXT_W   = DATA_W - ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] regs [NREG];
  logic [ADDR_W-1:0] pc;
  logic [INSN_W-1:0] ir;
  logic [DATA_W-1:0] valS, valT, valD;
  logic [DATA_W-1:0] aluOut, wbVal;
  logic [ADDR_W-1:0] memAddr, immAddr;
  logic [REG_AW-1:0] rdIdx, rsIdx, rtIdx;

  assign opcode  = ir[15:12];
  assign rdIdx   = ir[11:8];
  assign rsIdx   = ir[7:4];
  assign rtIdx   = ir[3:0];
  assign immAddr = ir[ADDR_W-1:0];

  // Indirect accesses take their address from the low bits of Rt
  assign memAddr = (opcode == OP_LDI || opcode == OP_STI) ? valT[ADDR_W-1:0] : immAddr;
  assign ioAddr  = (memAddr == '1);
  assign outData = valD;
  assign dIsZero = (valD == '0);
  assign dIsPos  = (valD != '0) && !valD[DATA_W-1];

  // Preload is honoured only inside reset; stores only while running
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (loadEn) mem[loadAddr] <= loadData;
    end else if (st.memWr) begin
      mem[memAddr] <= valD;
    end
  end

  always_comb begin
    unique case (opcode)
      OP_ADD:  aluOut = valS + valT;
      OP_SUB:  aluOut = valS - valT;
      OP_AND:  aluOut = valS & valT;
      OP_XOR:  aluOut = valS ^ valT;
      OP_SHL:  aluOut = (|valT[DATA_W-1:SH_W]) ? '0 : valS << valT[SH_W-1:0];
      OP_SHR:  aluOut = (|valT[DATA_W-1:SH_W]) ? '0 : valS >> valT[SH_W-1:0];
      default: aluOut = '0;
    endcase
  end

  always_comb begin
    unique case (st.wbSel)
      WB_ALU:  wbVal = aluOut;
      WB_IMM:  wbVal = {{EXT_W{1'b0}}, immAddr};
      WB_MEM:  wbVal = mem[memAddr];
      WB_IN:   wbVal = inData;
      WB_PC:   wbVal = {{EXT_W{1'b0}}, pc};
      default: wbVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (st.regWr && rdIdx != '0) begin
      regs[rdIdx] <= wbVal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= RESET_PC;
      ir   <= '0;
      valS <= '0;
      valT <= '0;
      valD <= '0;
    end else begin
      if (st.irLoad) begin
        ir <= mem[pc];
        pc <= pc + ADDR_W'(1);
      end else if (st.pcJump) begin
        pc <= st.pcFromReg ? valD[ADDR_W-1:0] : immAddr;
      end
      if (st.opLatch) begin
        valS <= (rsIdx == '0) ? '0 : regs[rsIdx];
        valT <= (rtIdx == '0) ? '0 : regs[rtIdx];
        valD <= (rdIdx == '0) ? '0 : regs[rdIdx];
      end
    end
  end

  p_fetch_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st.irLoad |=> pc == $past(pc) + ADDR_W'(1));

  p_no_io_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st.memWr |-> !ioAddr);

  p_operands_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !st.opLatch |=> $stable(valD));

endmodule

// File: rtl/mini16_ctrl.sv
module mini16_ctrl
  import mini16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  opcode,
  input  logic        ioAddr,
  input  logic        dIsZero,
  input  logic        dIsPos,
  input  logic        inValid,
  input  logic        outReady,
  output ctrlStrobe_t st,
  output logic        inReady,
  output logic        outValid,
  output logic        halted
);

  typedef enum logic [2:0] {
    S_FETCH,
    S_DECODE,
    S_EXEC,
    S_IN,
    S_OUT,
    S_HALT
  } state_t;

  state_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_FETCH;
    else        state <= nextState;
  end

  assign inReady  = (state == S_IN);
  assign outValid = (state == S_OUT);
  assign halted   = (state == S_HALT);

  always_comb begin
    st        = '0;
    st.wbSel  = WB_ALU;
    nextState = state;
    unique case (state)
      S_FETCH: begin
        st.irLoad = 1'b1;
        nextState = S_DECODE;
      end
      S_DECODE: begin
        st.opLatch = 1'b1;
        nextState  = S_EXEC;
      end
      S_EXEC: begin
        nextState = S_FETCH;
        unique case (opcode)
          OP_HALT: nextState = S_HALT;
          OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_SHL, OP_SHR: begin
            st.regWr = 1'b1;
            st.wbSel = WB_ALU;
          end
          OP_LDA: begin
            st.regWr = 1'b1;
            st.wbSel = WB_IMM;
          end
          OP_LD, OP_LDI: begin
            if (ioAddr) nextState = S_IN;
            else begin
              st.regWr = 1'b1;
              st.wbSel = WB_MEM;
            end
          end
          OP_ST, OP_STI: begin
            if (ioAddr) nextState = S_OUT;
            else        st.memWr  = 1'b1;
          end
          OP_BZ: st.pcJump = dIsZero;
          OP_BP: st.pcJump = dIsPos;
          OP_JR: begin
            st.pcJump    = 1'b1;
            st.pcFromReg = 1'b1;
          end
          OP_JAL: begin
            st.regWr  = 1'b1;
            st.wbSel  = WB_PC;
            st.pcJump = 1'b1;
          end
          default: nextState = S_FETCH;
        endcase
      end
      S_IN: begin
        if (inValid) begin
          st.regWr  = 1'b1;
          st.wbSel  = WB_IN;
          nextState = S_FETCH;
        end
      end
      S_OUT: if (outReady) nextState = S_FETCH;
      S_HALT: nextState = S_HALT;
      default: nextState = S_FETCH;
    endcase
  end

  p_in_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inReady && !inValid) |=> inReady);

  p_stream_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(inReady && outValid));

  p_out_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);

  p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!inReady && !outValid && !st.irLoad));

endmodule

// File: rtl/mini16_cpu.sv
module mini16_cpu
  import mini16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              halted
);

  ctrlStrobe_t st;
  logic [3:0]  opcode;
  logic        ioAddr, dIsZero, dIsPos;

  mini16_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .opcode   (opcode),
    .ioAddr   (ioAddr),
    .dIsZero  (dIsZero),
    .dIsPos   (dIsPos),
    .inValid  (inValid),
    .outReady (outReady),
    .st       (st),
    .inReady  (inReady),
    .outValid (outValid),
    .halted   (halted)
  );

  mini16_dpath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .RESET_PC (RESET_PC)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .inData   (inData),
    .outData  (outData),
    .opcode   (opcode),
    .ioAddr   (ioAddr),
    .dIsZero  (dIsZero),
    .dIsPos   (dIsPos)
  );

endmodule

// File: tb/sim_mini16_cpu.sv
`timescale 1ns/1ps
module sim_mini16_cpu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loadEn = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [15:0] loadData = '0;
  logic [15:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [15:0] outData;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        halted;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] img [256];
  logic [15:0] inq [16];
  int          inN;
  logic [15:0] expq [32];
  int          expN;
  logic [15:0] gotq [32];
  int          gotN;

  always #2 clk = ~clk;

  mini16_cpu u0 (
    .clk(clk), .rst_n(rst_n), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .inData(inData), .inValid(inValid),
    .inReady(inReady), .outData(outData), .outValid(outValid),
    .outReady(outReady), .halted(halted)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearImage();
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
  endtask

  // Instruction-level reference model built from the requirements
  task automatic modelRun();
    logic [15:0] mm [256];
    logic [15:0] rr [16];
    logic [7:0]  p;
    logic [15:0] ins, a, b, dv, res;
    logic [3:0]  op, d;
    logic [7:0]  ad;
    int k;
    for (int i = 0; i < 256; i++) mm[i] = img[i];
    for (int i = 0; i < 16; i++) rr[i] = '0;
    p = 8'h10; k = 0; expN = 0;
    for (int step = 0; step < 5000; step++) begin
      ins = mm[p]; p = p + 8'd1;
      op = ins[15:12]; d = ins[11:8];
      a = rr[ins[7:4]]; b = rr[ins[3:0]]; dv = rr[d];
      ad = (op == 4'hA || op == 4'hB) ? b[7:0] : ins[7:0];
      if (op == 4'h0) break;
      case (op)
        4'h1: rr[d] = a + b;
        4'h2: rr[d] = a - b;
        4'h3: rr[d] = a & b;
        4'h4: rr[d] = a ^ b;
        4'h5: rr[d] = (b >= 16) ? 16'h0 : a << b[3:0];
        4'h6: rr[d] = (b >= 16) ? 16'h0 : a >> b[3:0];
        4'h7: rr[d] = {8'h00, ins[7:0]};
        4'h8, 4'hA: begin
          if (ad == 8'hFF) begin res = inq[k]; k++; end
          else res = mm[ad];
          rr[d] = res;
        end
        4'h9, 4'hB: begin
          if (ad == 8'hFF) begin if (expN < 32) expq[expN] = dv; expN++; end
          else mm[ad] = dv;
        end
        4'hC: if (dv == 0) p = ins[7:0];
        4'hD: if (dv != 0 && !dv[15]) p = ins[7:0];
        4'hE: p = dv[7:0];
        4'hF: begin rr[d] = {8'h00, p}; p = ins[7:0]; end
        default: ;
      endcase
      rr[0] = '0;
    end
  endtask

  task automatic preloadReset(input bit doLoad);
    @(negedge clk);
    rst_n = 1'b0; inValid = 1'b0; outReady = 1'b0;
    if (doLoad) begin
      for (int i = 0; i < 256; i++) begin
        loadEn = 1'b1; loadAddr = 8'(i); loadData = img[i];
        @(negedge clk);
      end
      loadEn = 1'b0;
    end else begin
      repeat (3) @(negedge clk);
    end
    // R1: outputs quiet while reset is held
    chk(!halted && !inReady && !outValid, "R1 reset outputs",
        {13'b0, halted, inReady, outValid}, 16'h0000);
    rst_n = 1'b1;
  endtask

  task automatic runProg(input bit bp);
    int inIdx = 0;
    int cyc = 0;
    gotN = 0;
    while (!halted && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      inValid  = (inIdx < inN) && (!bp || (cyc % 3 != 0));
      inData   = inq[inIdx < 16 ? inIdx : 0];
      outReady = !bp || (cyc % 2 == 0);
      if (inValid && inReady) inIdx++;
      if (outValid && outReady) begin
        if (gotN < 32) gotq[gotN] = outData;
        gotN++;
      end
    end
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b0;
    chk(halted, "R11 program reaches halt", {15'b0, halted}, 16'h0001);
  endtask

  task automatic compareOut(input string tag);
    chk(gotN == expN, {tag, " output count"}, 16'(gotN), 16'(expN));
    for (int i = 0; i < expN && i < 32; i++)
      chk(i < gotN && gotq[i] == expq[i], {tag, " output word"}, gotq[i], expq[i]);
  endtask

  task automatic testResetStart();
    clearImage();
    img[8'h00] = 16'h7155;
    img[8'h01] = 16'h91FF;
    img[8'h10] = 16'h7142;
    img[8'h11] = 16'h91FF;
    img[8'h12] = 16'h92FF;
    inN = 0;
    modelRun();
    preloadReset(1'b1);
    runProg(1'b0);
    compareOut("R1 start address and cleared registers");
  endtask

  task automatic loadEchoImage();
    clearImage();
    img[8'h10] = 16'h7101; img[8'h11] = 16'h7A30; img[8'h12] = 16'h7C00;
    img[8'h13] = 16'h8DFF; img[8'h14] = 16'hCD1A; img[8'h15] = 16'h12AC;
    img[8'h16] = 16'hBD02; img[8'h17] = 16'h9DFF; img[8'h18] = 16'h1CC1;
    img[8'h19] = 16'hC013; img[8'h1A] = 16'h9CFF; img[8'h1B] = 16'h8330;
    img[8'h1C] = 16'h93FF; img[8'h1D] = 16'hA402; img[8'h1E] = 16'h94FF;
    img[8'h1F] = 16'h0000;
  endtask

  task automatic testEcho();
    loadEchoImage();
    inq[0] = 16'h0005; inq[1] = 16'hFFFF; inq[2] = 16'h1234; inq[3] = 16'h0000;
    inN = 4;
    modelRun();
    preloadReset(1'b1);
    runProg(1'b0);
    compareOut("R2/R6/R7/R8 echo");
  endtask

  task automatic testEchoBackpressure();
    loadEchoImage();
    inq[0] = 16'h0007; inq[1] = 16'h8000; inq[2] = 16'h00FF; inq[3] = 16'h0000;
    inN = 4;
    modelRun();
    preloadReset(1'b1);
    runProg(1'b1);
    compareOut("R7/R8 stalled echo");
  endtask

  task automatic testAlu();
    clearImage();
    img[8'h10] = 16'h7105; img[8'h11] = 16'h7203; img[8'h12] = 16'h1312;
    img[8'h13] = 16'h93FF; img[8'h14] = 16'h2421; img[8'h15] = 16'h94FF;
    img[8'h16] = 16'h3512; img[8'h17] = 16'h95FF; img[8'h18] = 16'h4612;
    img[8'h19] = 16'h96FF; img[8'h1A] = 16'h5712; img[8'h1B] = 16'h97FF;
    img[8'h1C] = 16'h78F0; img[8'h1D] = 16'h7911; img[8'h1E] = 16'h5A19;
    img[8'h1F] = 16'h9AFF; img[8'h20] = 16'h6B82; img[8'h21] = 16'h9BFF;
    img[8'h22] = 16'h1011; img[8'h23] = 16'h90FF; img[8'h24] = 16'h6D42;
    img[8'h25] = 16'h9DFF; img[8'h26] = 16'h7C10; img[8'h27] = 16'h6E4C;
    img[8'h28] = 16'h9EFF; img[8'h29] = 16'h2F02; img[8'h2A] = 16'h9FFF;
    img[8'h2B] = 16'h0000;
    inN = 0;
    modelRun();
    // R3: 5+3 = 8, 3-5 wraps to FFFE
    chk(expq[0] == 16'h0008 && expq[1] == 16'hFFFE, "R3 model sanity", expq[1], 16'hFFFE);
    preloadReset(1'b1);
    runProg(1'b0);
    compareOut("R3/R4/R5 arithmetic and shifts");
  endtask

  task automatic testFlow();
    clearImage();
    img[8'h10] = 16'h7180; img[8'h11] = 16'h2201; img[8'h12] = 16'hD215;
    img[8'h13] = 16'h7301; img[8'h14] = 16'h93FF; img[8'h15] = 16'hD118;
    img[8'h16] = 16'h7302; img[8'h17] = 16'h93FF; img[8'h18] = 16'hC01B;
    img[8'h1B] = 16'hF430;
    img[8'h30] = 16'h94FF; img[8'h31] = 16'h7520; img[8'h32] = 16'hE500;
    img[8'h20] = 16'hC21F; img[8'h21] = 16'h7633; img[8'h22] = 16'h96FF;
    img[8'h23] = 16'hD026; img[8'h24] = 16'h7744; img[8'h25] = 16'h97FF;
    img[8'h26] = 16'h0000;
    inN = 0;
    modelRun();
    // R10: link value is the address after the jump-and-link at 1B
    chk(expq[1] == 16'h001C, "R10 model link", expq[1], 16'h001C);
    preloadReset(1'b1);
    runProg(1'b0);
    compareOut("R9/R10 branches and jumps");
  endtask

  task automatic testHaltAndPreload();
    clearImage();
    img[8'h10] = 16'h8140; img[8'h11] = 16'h91FF; img[8'h12] = 16'h0000;
    img[8'h40] = 16'hABCD;
    inN = 0;
    modelRun();
    preloadReset(1'b1);
    runProg(1'b0);
    compareOut("R6 direct load");
    // R12: preload attempts while running, R11: halt holds
    for (int i = 0; i < 6; i++) begin
      loadEn = 1'b1; loadAddr = 8'h40; loadData = 16'h5555;
      outReady = 1'b1; inValid = 1'b1;
      @(negedge clk);
      chk(halted && !outValid && !inReady, "R11 halt holds quiet",
          {13'b0, halted, outValid, inReady}, 16'h0004);
    end
    loadEn = 1'b0; outReady = 1'b0; inValid = 1'b0;
    preloadReset(1'b0);
    runProg(1'b0);
    chk(gotN == 1 && gotq[0] == 16'hABCD, "R12 preload ignored after reset",
        gotq[0], 16'hABCD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    testResetStart();
    testEcho();
    testEchoBackpressure();
    testAlu();
    testFlow();
    testHaltAndPreload();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule